// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides the outcome of a single-precision fused multiply-add (a*b+c) or of a two-operand operation whenever a NaN rule applies. Each operand is classified as quiet NaN, signalling NaN, infinity or zero. A rule set is then chosen from two controls: the operand count and a handling mode. That rule set picks which operand, if any, becomes the result. It also covers the product of zero and infinity, and it can force the canonical NaN in place of any propagated NaN.

The arithmetic is computed elsewhere and presented on `arith_res`. When no NaN rule applies, that word passes through unchanged and both flags stay low. The decision is registered once: a request accepted with `req_valid` produces its result on the next clock edge with `rsp_valid` high. The outputs hold their last value while no request arrives.

The four rule sets are the states of the selection logic:
- `RULE_STD2`: standard handling, two operands.
- `RULE_ALT2`: alternate handling, two operands.
- `RULE_STD3`: standard handling, three operands.
- `RULE_ALT3`: alternate handling, three operands.

One is chosen in each cycle from `three_op` and `alt_mode`. No state carries over between requests.

Top module: `fma_nan_select`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `rsp_valid`, `nan_out` and `invalid_out` are 0 and `result` is 0.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. While `req_valid` is low, `result`, `nan_out` and `invalid_out` keep their previous values.
- R3: When no NaN rule applies, `result` equals `arith_res` and both flags are 0. No NaN rule applies when no NaN is present among the considered operands and there is no three-operand 0*Inf product.
- R4: Standard two-operand rule: a signalling NaN beats a quiet NaN. Among equals, A beats B.
- R5: Alternate two-operand rule: the first NaN among A, B is returned, regardless of whether it is signalling or quiet.
- R6: Standard three-operand rule: a signalling NaN beats a quiet NaN. Among equals, the order is C, then A, then B.
- R7: Alternate three-operand rule: the first NaN in the order A, B, C is returned, regardless of whether it is signalling or quiet.
- R8: A propagated NaN is quieted by setting fraction bit 22. When the result is a NaN, `nan_out` is 1. `invalid_out` is 1 if any considered operand is a signalling NaN, and 0 when only quiet NaNs are present outside the 0*Inf case.
- R9: Standard mode, three operands, A*B is 0*Inf (either order, either sign), C a NaN: a quiet C gives the default NaN, a signalling C gives quieted C. Both set `invalid_out`.
- R10: Alternate mode, same 0*Inf case with C a NaN: the result is quieted C. `invalid_out` is 1 only if C is signalling.
- R11: Three operands, A*B is 0*Inf, and no NaN operand: the result is the default NaN with `invalid_out` = 1, in both modes.
- R12: The default NaN has exponent all ones, fraction bit 22 set and all other fraction bits clear. Its sign is 0 in standard mode and 1 in alternate mode (0x7FC00000 / 0xFFC00000).
- R13: With `dnan_en` = 1, every NaN result is replaced by the default NaN of the current mode, and `invalid_out` is unchanged. Non-NaN results are unaffected.
- R14: With `three_op` = 0, operand C and the 0*Inf rule have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; the inputs are captured on this cycle |
| op_a | input | 32 | Multiplicand / first operand |
| op_b | input | 32 | Multiplier / second operand |
| op_c | input | 32 | Addend (three-operand only) |
| three_op | input | 1 | 1: a*b+c, 0: two-operand operation on A and B |
| alt_mode | input | 1 | 0: standard rule set, 1: alternate rule set |
| dnan_en | input | 1 | Replace any NaN result by the default NaN |
| arith_res | input | 32 | Arithmetic result used when no NaN rule applies |
| rsp_valid | output | 1 | Result valid, one cycle after `req_valid` |
| result | output | 32 | Selected result word |
| nan_out | output | 1 | Result is a NaN produced by this block |
| invalid_out | output | 1 | Invalid operation raised |

## Verification
The bench builds the block with its default 8-bit exponent and 23-bit fraction, which is the single-precision format. The operand codes and the default NaN words therefore appear as literal 32-bit values in the checks. At this width, signalling and quiet NaNs with distinct payloads and signs can be told apart in the result. This shows which operand won the priority contest and that it was quieted. Both zero signs and both product orders reach the 0*Inf path.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } opclass_t;

    typedef enum logic [1:0] {
        RULE_STD2 = 2'd0,
        RULE_ALT2 = 2'd1,
        RULE_STD3 = 2'd2,
        RULE_ALT3 = 2'd3
    } rule_t;

    typedef enum logic [2:0] {
        PICK_ARITH = 3'd0,
        PICK_A     = 3'd1,
        PICK_B     = 3'd2,
        PICK_C     = 3'd3,
        PICK_DNAN  = 3'd4
    } pick_t;

endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify
    import fma_nan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output opclass_t              cls
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              unused_sign;

    assign expo        = word[FRAC_W +: EXP_W];
    assign frac        = word[FRAC_W-1:0];
    assign unused_sign = word[W-1];

    always_comb begin
        cls.is_nan  = (&expo) && (|frac);
        cls.is_snan = (&expo) && (|frac) && !frac[FRAC_W-1];
        cls.is_inf  = (&expo) && !(|frac);
        cls.is_zero = !(|expo) && !(|frac);
    end

endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
    import fma_nan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    input  logic [EXP_W+FRAC_W:0] c,
    input  opclass_t              ca,
    input  opclass_t              cb,
    input  opclass_t              cc,
    input  logic                  three_op,
    input  logic                  alt_mode,
    input  logic                  dnan_en,
    input  logic [EXP_W+FRAC_W:0] arith,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  nan_res,
    output logic                  invalid
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

    rule_t      rule;
    pick_t      pick;
    logic       inf_zero;
    logic       unused_c;
    logic [W-1:0] dnan;

    assign rule     = rule_t'({three_op, alt_mode});
    assign inf_zero = (ca.is_zero && cb.is_inf) || (ca.is_inf && cb.is_zero);
    assign unused_c = cc.is_inf ^ cc.is_zero;
    assign dnan     = {alt_mode, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    always_comb begin
        pick    = PICK_ARITH;
        invalid = 1'b0;
        unique case (rule)
            RULE_STD2: begin
                invalid = ca.is_snan || cb.is_snan;
                if (ca.is_snan)      pick = PICK_A;
                else if (cb.is_snan) pick = PICK_B;
                else if (ca.is_nan)  pick = PICK_A;
                else if (cb.is_nan)  pick = PICK_B;
            end
            RULE_ALT2: begin
                invalid = ca.is_snan || cb.is_snan;
                if (ca.is_nan)      pick = PICK_A;
                else if (cb.is_nan) pick = PICK_B;
            end
            RULE_STD3: begin
                invalid = ca.is_snan || cb.is_snan || cc.is_snan;
                if (inf_zero) begin
                    invalid = 1'b1;
                    pick    = cc.is_snan ? PICK_C : PICK_DNAN;
                end
                else if (cc.is_snan) pick = PICK_C;
                else if (ca.is_snan) pick = PICK_A;
                else if (cb.is_snan) pick = PICK_B;
                else if (cc.is_nan)  pick = PICK_C;
                else if (ca.is_nan)  pick = PICK_A;
                else if (cb.is_nan)  pick = PICK_B;
            end
            RULE_ALT3: begin
                invalid = ca.is_snan || cb.is_snan || cc.is_snan;
                if (inf_zero) begin
                    if (cc.is_nan) begin
                        pick = PICK_C;
                    end
                    else begin
                        pick    = PICK_DNAN;
                        invalid = 1'b1;
                    end
                end
                else if (ca.is_nan) pick = PICK_A;
                else if (cb.is_nan) pick = PICK_B;
                else if (cc.is_nan) pick = PICK_C;
            end
            default: pick = PICK_ARITH;
        endcase
    end

    always_comb begin
        nan_res = (pick != PICK_ARITH);
        unique case (pick)
            PICK_A:    res = a | QUIET_BIT;
            PICK_B:    res = b | QUIET_BIT;
            PICK_C:    res = c | QUIET_BIT;
            PICK_DNAN: res = dnan;
            default:   res = arith;
        endcase
        if (dnan_en && nan_res) begin
            res = dnan;
        end
    end

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  logic                  three_op,
    input  logic                  alt_mode,
    input  logic                  dnan_en,
    input  logic [EXP_W+FRAC_W:0] arith_res,
    output logic                  rsp_valid,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  nan_out,
    output logic                  invalid_out
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int N_OPS = 3;

    logic [W-1:0] ops [N_OPS];
    opclass_t     cls [N_OPS];
    logic [W-1:0] res_d;
    logic         nan_d;
    logic         inv_d;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fma_nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word (ops[gi]),
            .cls  (cls[gi])
        );
    end

    fma_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
        .a        (op_a),
        .b        (op_b),
        .c        (op_c),
        .ca       (cls[0]),
        .cb       (cls[1]),
        .cc       (cls[2]),
        .three_op (three_op),
        .alt_mode (alt_mode),
        .dnan_en  (dnan_en),
        .arith    (arith_res),
        .res      (res_d),
        .nan_res  (nan_d),
        .invalid  (inv_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            result      <= '0;
            nan_out     <= 1'b0;
            invalid_out <= 1'b0;
        end
        else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                result      <= res_d;
                nan_out     <= nan_d;
                invalid_out <= inv_d;
            end
        end
    end

endmodule

// File: rtl/fma_nan_select_chk.sv
module fma_nan_select_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic [EXP_W+FRAC_W:0] op_c,
    input logic                  three_op,
    input logic                  alt_mode,
    input logic                  dnan_en,
    input logic [EXP_W+FRAC_W:0] arith_res,
    input logic                  rsp_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  nan_out,
    input logic                  invalid_out
);
    localparam int W = 1 + EXP_W + FRAC_W;

    function automatic logic f_nan(input logic [W-1:0] v);
        return (&v[FRAC_W +: EXP_W]) && (|v[FRAC_W-1:0]);
    endfunction

    function automatic logic f_inf(input logic [W-1:0] v);
        return (&v[FRAC_W +: EXP_W]) && !(|v[FRAC_W-1:0]);
    endfunction

    function automatic logic f_zero(input logic [W-1:0] v);
        return v[W-2:0] == '0;
    endfunction

    logic quiet_case;
    assign quiet_case = !f_nan(op_a) && !f_nan(op_b) &&
        !(three_op && (f_nan(op_c) || (f_zero(op_a) && f_inf(op_b)) ||
                       (f_inf(op_a) && f_zero(op_b))));

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(result) && $stable(nan_out) && $stable(invalid_out)); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && quiet_case |=> result == $past(arith_res) && !nan_out && !invalid_out); // R3

    AST_NAN_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nan_out |-> (&result[FRAC_W +: EXP_W]) && result[FRAC_W-1]); // R8

    AST_INVALID_WITH_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_out |-> nan_out); // R11

    AST_DNAN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && dnan_en |=> !nan_out ||
            result == {$past(alt_mode), {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}); // R13

endmodule

bind fma_nan_select fma_nan_select_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .op_a        (op_a),
    .op_b        (op_b),
    .op_c        (op_c),
    .three_op    (three_op),
    .alt_mode    (alt_mode),
    .dnan_en     (dnan_en),
    .arith_res   (arith_res),
    .rsp_valid   (rsp_valid),
    .result      (result),
    .nan_out     (nan_out),
    .invalid_out (invalid_out)
);

// File: tb/fma_nan_select_tb.sv
module fma_nan_select_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] QA    = 32'h7FC0_0001;
    localparam logic [31:0] SA    = 32'h7F80_0002;
    localparam logic [31:0] QB    = 32'hFFC0_0003;
    localparam logic [31:0] SB    = 32'hFF80_0004;
    localparam logic [31:0] QC    = 32'h7FC0_0005;
    localparam logic [31:0] SC    = 32'h7F80_0006;
    localparam logic [31:0] ONE   = 32'h3F80_0000;
    localparam logic [31:0] TWO   = 32'h4000_0000;
    localparam logic [31:0] PZERO = 32'h0000_0000;
    localparam logic [31:0] NZERO = 32'h8000_0000;
    localparam logic [31:0] INF   = 32'h7F80_0000;
    localparam logic [31:0] DN_S  = 32'h7FC0_0000;
    localparam logic [31:0] DN_A  = 32'hFFC0_0000;
    localparam logic [31:0] ARITH = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0, arith_res = '0;
    logic        three_op = 1'b0, alt_mode = 1'b0, dnan_en = 1'b0;
    logic        rsp_valid, nan_out, invalid_out;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_nan_select dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .three_op(three_op), .alt_mode(alt_mode), .dnan_en(dnan_en),
        .arith_res(arith_res), .rsp_valid(rsp_valid), .result(result),
        .nan_out(nan_out), .invalid_out(invalid_out)
    );

    task automatic check(input string tag, input logic [31:0] exp_res,
                         input logic exp_nan, input logic exp_inv);
        n_tests++;
        if (result !== exp_res || nan_out !== exp_nan || invalid_out !== exp_inv) begin
            n_fail++;
            $display("FAIL %s: res=%h nan=%b inv=%b expected res=%h nan=%b inv=%b",
                     tag, result, nan_out, invalid_out, exp_res, exp_nan, exp_inv);
        end
    endtask

    // Drive one request at a falling edge; the result is registered at the
    // next rising edge and sampled at the falling edge after it.
    task automatic issue(input logic [31:0] a, b, c, input logic three,
                         input logic alt, input logic dn);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; three_op = three;
        alt_mode = alt; dnan_en = dn; arith_res = ARITH; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_tests++;
        if (rsp_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2: rsp_valid=%b expected 1", rsp_valid);
        end
    endtask

    task automatic t_reset();
        n_tests++;
        if (rsp_valid !== 1'b0 || result !== 32'h0 || nan_out !== 1'b0 || invalid_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: valid=%b res=%h nan=%b inv=%b expected 0 00000000 0 0",
                     rsp_valid, result, nan_out, invalid_out);
        end
    endtask

    task automatic t_passthrough();
        issue(ONE, TWO, ONE, 1'b1, 1'b0, 1'b0);
        check("R3 three-op numbers", ARITH, 1'b0, 1'b0);
        issue(ONE, TWO, ONE, 1'b1, 1'b1, 1'b1);
        check("R13 dnan_en with numbers", ARITH, 1'b0, 1'b0);
        issue(QA, QB, ONE, 1'b0, 1'b0, 1'b0);
        // idle cycle with different inputs: outputs must hold
        @(negedge clk);
        op_a = ONE; op_b = ONE; arith_res = 32'h0BAD_0BAD;
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: idle rsp_valid=%b expected 0", rsp_valid);
        end
        check("R2 hold while idle", QA, 1'b1, 1'b0);
    endtask

    task automatic t_std2();
        issue(QA, SB, ONE, 1'b0, 1'b0, 1'b0);
        check("R4 sNaN B beats qNaN A", 32'hFFC0_0004, 1'b1, 1'b1);
        issue(SA, SB, ONE, 1'b0, 1'b0, 1'b0);
        check("R4 A beats B among sNaN", 32'h7FC0_0002, 1'b1, 1'b1);
        issue(ONE, QB, ONE, 1'b0, 1'b0, 1'b0);
        check("R8 lone qNaN no invalid", QB, 1'b1, 1'b0);
    endtask

    task automatic t_alt2();
        issue(QA, SB, ONE, 1'b0, 1'b1, 1'b0);
        check("R5 first NaN A wins", QA, 1'b1, 1'b1);
        issue(ONE, SB, ONE, 1'b0, 1'b1, 1'b0);
        check("R5 B quieted", 32'hFFC0_0004, 1'b1, 1'b1);
    endtask

    task automatic t_std3();
        issue(QA, SB, QC, 1'b1, 1'b0, 1'b0);
        check("R6 sNaN first", 32'hFFC0_0004, 1'b1, 1'b1);
        issue(QA, QB, QC, 1'b1, 1'b0, 1'b0);
        check("R6 C first among qNaN", QC, 1'b1, 1'b0);
        issue(SA, ONE, SC, 1'b1, 1'b0, 1'b0);
        check("R6 C first among sNaN", 32'h7FC0_0006, 1'b1, 1'b1);
    endtask

    task automatic t_alt3();
        issue(ONE, QB, SC, 1'b1, 1'b1, 1'b0);
        check("R7 B before C no sNaN priority", QB, 1'b1, 1'b1);
        issue(QA, SB, SC, 1'b1, 1'b1, 1'b0);
        check("R7 A first", QA, 1'b1, 1'b1);
    endtask

    task automatic t_inf_zero();
        issue(PZERO, INF, QC, 1'b1, 1'b0, 1'b0);
        check("R9 0*Inf+qNaN std", DN_S, 1'b1, 1'b1);
        issue(INF, NZERO, SC, 1'b1, 1'b0, 1'b0);
        check("R9 0*Inf+sNaN std", 32'h7FC0_0006, 1'b1, 1'b1);
        issue(INF, NZERO, QC, 1'b1, 1'b1, 1'b0);
        check("R10 0*Inf+qNaN alt", QC, 1'b1, 1'b0);
        issue(PZERO, INF, SC, 1'b1, 1'b1, 1'b0);
        check("R10 0*Inf+sNaN alt", 32'h7FC0_0006, 1'b1, 1'b1);
        issue(PZERO, INF, ONE, 1'b1, 1'b0, 1'b0);
        check("R11 0*Inf std", DN_S, 1'b1, 1'b1);
        issue(NZERO, INF, ONE, 1'b1, 1'b1, 1'b0);
        check("R11 R12 0*Inf alt", DN_A, 1'b1, 1'b1);
    endtask

    task automatic t_dnan();
        issue(QA, QB, ONE, 1'b0, 1'b0, 1'b1);
        check("R13 R12 forced dnan std", DN_S, 1'b1, 1'b0);
        issue(SA, QB, QC, 1'b1, 1'b1, 1'b1);
        check("R13 R12 forced dnan alt", DN_A, 1'b1, 1'b1);
    endtask

    task automatic t_two_op_c();
        issue(ONE, TWO, SC, 1'b0, 1'b0, 1'b0);
        check("R14 C ignored", ARITH, 1'b0, 1'b0);
        issue(PZERO, INF, QC, 1'b0, 1'b1, 1'b0);
        check("R14 no 0*Inf rule", ARITH, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_std2();
        t_alt2();
        t_std3();
        t_alt3();
        t_inf_zero();
        t_dnan();
        t_two_op_c();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule